// File: doc/BRIEF.md
# HUB75 Row Shift and Latch Sequencer

This block drives the control side of one row of a HUB75 LED panel. After a start strobe it shifts a row of serial colour bits out on a data clock. Each data clock carries two pixels, one on the upper RGB lane and one on the lower RGB lane. It then blanks the panel, puts the new row address on the address lines, pulses the latch, re-enables the display and raises a one-cycle done flag. An upstream fetch unit reads the column index the block presents and returns the two pixels for that column in the same cycle.

Two latch/output-enable orderings can be selected at run time. In **offset** ordering the display is re-enabled while the latch is still high. In **enclosed** ordering the latch pulse lies completely inside the blanked window. The latch can rise after the row has been shifted (**after** position), or early, together with the third-from-last column of data (**overlap** position). A wide-clock option stretches the high half of every data clock by a programmable number of cycles, for panel drivers that have a slower maximum shift rate.

The FSM states are IDLE, CLK_LO, CLK_HI, BLANK, ADDR, LATCH, OE_ON_LAT, LAT_OFF, SHOW and FINISH. The transitions are:
- IDLE→CLK_LO on start.
- CLK_LO→CLK_HI when the low phase expires.
- CLK_HI→CLK_LO when more columns remain; CLK_HI→BLANK after the last column.
- BLANK→ADDR→LATCH, each after the gap time.
- LATCH→OE_ON_LAT in offset ordering; LATCH→LAT_OFF in enclosed ordering.
- OE_ON_LAT or LAT_OFF→SHOW.
- SHOW→FINISH.
- FINISH→IDLE after one cycle.

Top module: `panel_row_sequencer`

## Requirements
- R1: After reset, and whenever idle, `hub_clk`, `hub_lat`, `hub_oe_n` and `row_done` are 0 and `pix_col` is 0. After reset the data and address lines are 0.
- R2: `start` is accepted only in IDLE. At acceptance the block captures `cfg_*` and `next_row`. A `start` pulse, or any change of the configuration inputs, while a row is in progress has no effect on the outputs.
- R3: Column c is handled as follows:
  - In the cycle before column c is loaded, `pix_col` equals c.
  - The pixels for column c appear on `hub_rgb_top`/`hub_rgb_bot` on the first cycle of its clock-low phase and hold through its clock-high phase.
  - While column c is being shifted, `pix_col` reads c+1.
- R4: With `cfg_wide`=0, each column has LOW_CYC cycles with `hub_clk`=0 followed by HIGH_CYC cycles with `hub_clk`=1. Exactly COLS clocks are sent.
- R5: With `cfg_wide`=1, each clock-high phase lasts HIGH_CYC+`cfg_stretch` cycles.
- R6: After the last high phase, the following happens in order, each step lasting GAP_CYC cycles:
  - `hub_oe_n` rises.
  - `hub_addr` takes the captured row.
  - `hub_lat` is 1; in after position it rises here.
- R7: Offset ordering (`cfg_enclosed`=0): GAP_CYC cycles after the latch step, `hub_oe_n` falls while `hub_lat` stays 1. After a further GAP_CYC cycles, `hub_lat` falls.
- R8: Enclosed ordering (`cfg_enclosed`=1): GAP_CYC cycles after the latch step, `hub_lat` falls while `hub_oe_n` stays 1. After a further GAP_CYC cycles, `hub_oe_n` falls.
- R9: Overlap position (`cfg_overlap`=1): `hub_lat` rises in the same cycle as the data of column COLS-3 and stays 1 until its falling step in R7/R8. In after position, `hub_lat` is 0 throughout shifting.
- R10: `row_done` is 1 for exactly one cycle, GAP_CYC cycles after both `hub_lat` and `hub_oe_n` are 0. The block then returns to IDLE.
- R11: Between rows, the data and address lines hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin one row (accepted in IDLE) |
| cfg_enclosed | input | 1 | 1 = enclosed latch ordering, 0 = offset |
| cfg_overlap | input | 1 | 1 = latch overlaps last three columns |
| cfg_wide | input | 1 | Enable stretched clock-high phase |
| cfg_stretch | input | STRETCH_W | Extra clock-high cycles when wide |
| next_row | input | ADDR_W | Row address to present after shifting |
| pix_col | output | COL_W | Column index requested from fetch unit |
| pix_top | input | 3 | Upper-lane RGB bits for `pix_col` |
| pix_bot | input | 3 | Lower-lane RGB bits for `pix_col` |
| hub_clk | output | 1 | Panel data clock (rising edge samples) |
| hub_rgb_top | output | 3 | Upper-lane RGB lines |
| hub_rgb_bot | output | 3 | Lower-lane RGB lines |
| hub_addr | output | ADDR_W | Panel row address lines |
| hub_lat | output | 1 | Panel latch |
| hub_oe_n | output | 1 | Panel output enable, active low |
| row_done | output | 1 | One-cycle row completion pulse |

## Verification
The most likely internal faults each show up at the ports within a cycle or one phase.
- A wrong state or timer value moves an edge of `hub_clk`, `hub_oe_n` or `hub_lat` by at least one cycle. The per-cycle comparison catches this on the cycle the edge should have occurred.
- A column counter that is off by one shows as a wrong `pix_col` at once, and as wrong RGB data one clock-low phase later.
- A mis-captured configuration shows as the wrong latch order or clock width in the first affected phase.
- A branch taken in the wrong direction after the latch step swaps which of `hub_lat` and `hub_oe_n` falls first, within GAP_CYC cycles.

// File: rtl/rowseq_pkg.sv
package rowseq_pkg;

    typedef enum logic [3:0] {
        S_IDLE      = 4'd0,
        S_CLK_LO    = 4'd1,
        S_CLK_HI    = 4'd2,
        S_BLANK     = 4'd3,
        S_ADDR      = 4'd4,
        S_LATCH     = 4'd5,
        S_OE_ON_LAT = 4'd6,
        S_LAT_OFF   = 4'd7,
        S_SHOW      = 4'd8,
        S_FINISH    = 4'd9
    } seq_state_e;

    localparam int LANE_BITS = 3;

endpackage

// File: rtl/rowseq_phase_timer.sv
module rowseq_phase_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/rowseq_col_counter.sv
module rowseq_col_counter #(
    parameter int COLS  = 8,
    parameter int COL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    output logic [COL_W-1:0] col,
    output logic             at_end,
    output logic             in_tail
);
    logic [COL_W-1:0] col_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q <= '0;
        end else if (clear) begin
            col_q <= '0;
        end else if (step) begin
            col_q <= col_q + 1'b1;
        end
    end

    assign col     = col_q;
    assign at_end  = (col_q == COL_W'(COLS));
    // after column COLS-3 has been loaded the count reads COLS-2
    assign in_tail = (col_q >= COL_W'(COLS - 2));

    // R3
    col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        col_q <= COL_W'(COLS));
endmodule

// File: rtl/rowseq_pixel_hold.sv
module rowseq_pixel_hold #(
    parameter int LANES  = 2,
    parameter int ADDR_W = 5
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  load_px,
    input  logic [LANES*rowseq_pkg::LANE_BITS-1:0] px_in,
    input  logic                                  load_addr,
    input  logic [ADDR_W-1:0]                     addr_in,
    output logic [LANES*rowseq_pkg::LANE_BITS-1:0] px_out,
    output logic [ADDR_W-1:0]                     addr_out
);
    import rowseq_pkg::*;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_BITS-1:0] lane_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else if (load_px) begin
                lane_q <= px_in[g*LANE_BITS +: LANE_BITS];
            end
        end
        assign px_out[g*LANE_BITS +: LANE_BITS] = lane_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_out <= '0;
        end else if (load_addr) begin
            addr_out <= addr_in;
        end
    end
endmodule

// File: rtl/panel_row_sequencer.sv
module panel_row_sequencer #(
    parameter int COLS      = 8,
    parameter int ADDR_W    = 5,
    parameter int LOW_CYC   = 2,
    parameter int HIGH_CYC  = 2,
    parameter int GAP_CYC   = 2,
    parameter int STRETCH_W = 3,
    localparam int COL_W    = $clog2(COLS + 1),
    localparam int TW       = $clog2(LOW_CYC + HIGH_CYC + GAP_CYC + (1 << STRETCH_W))
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 cfg_enclosed,
    input  logic                 cfg_overlap,
    input  logic                 cfg_wide,
    input  logic [STRETCH_W-1:0] cfg_stretch,
    input  logic [ADDR_W-1:0]    next_row,
    output logic [COL_W-1:0]     pix_col,
    input  logic [2:0]           pix_top,
    input  logic [2:0]           pix_bot,
    output logic                 hub_clk,
    output logic [2:0]           hub_rgb_top,
    output logic [2:0]           hub_rgb_bot,
    output logic [ADDR_W-1:0]    hub_addr,
    output logic                 hub_lat,
    output logic                 hub_oe_n,
    output logic                 row_done
);
    import rowseq_pkg::*;

    localparam int LANES = 2;

    seq_state_e state_q, state_d;

    logic                 enc_q, ovl_q, wide_q;
    logic [STRETCH_W-1:0] stretch_q;
    logic [ADDR_W-1:0]    row_q;

    logic                 phase_done;
    logic                 col_end, col_tail;
    logic                 entering;
    logic [TW-1:0]        dur;
    logic [LANES*3-1:0]   px_bus;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (start)      state_d = S_CLK_LO;
            S_CLK_LO:    if (phase_done) state_d = S_CLK_HI;
            S_CLK_HI:    if (phase_done) state_d = col_end ? S_BLANK : S_CLK_LO;
            S_BLANK:     if (phase_done) state_d = S_ADDR;
            S_ADDR:      if (phase_done) state_d = S_LATCH;
            S_LATCH:     if (phase_done) state_d = enc_q ? S_LAT_OFF : S_OE_ON_LAT;
            S_OE_ON_LAT: if (phase_done) state_d = S_SHOW;
            S_LAT_OFF:   if (phase_done) state_d = S_SHOW;
            S_SHOW:      if (phase_done) state_d = S_FINISH;
            S_FINISH:    state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    // ---------------- configuration capture ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enc_q     <= 1'b0;
            ovl_q     <= 1'b0;
            wide_q    <= 1'b0;
            stretch_q <= '0;
            row_q     <= '0;
        end else if (state_q == S_IDLE && start) begin
            enc_q     <= cfg_enclosed;
            ovl_q     <= cfg_overlap;
            wide_q    <= cfg_wide;
            stretch_q <= cfg_stretch;
            row_q     <= next_row;
        end
    end

    // ---------------- phase durations ----------------
    assign entering = (state_d != state_q);

    always_comb begin
        unique case (state_d)
            S_CLK_LO: dur = TW'(LOW_CYC - 1);
            S_CLK_HI: dur = TW'(HIGH_CYC - 1) + (wide_q ? TW'(stretch_q) : TW'(0));
            S_BLANK, S_ADDR, S_LATCH, S_OE_ON_LAT, S_LAT_OFF, S_SHOW:
                      dur = TW'(GAP_CYC - 1);
            default:  dur = '0;
        endcase
    end

    rowseq_phase_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (entering),
        .load_val (dur),
        .expired  (phase_done)
    );

    rowseq_col_counter #(.COLS(COLS), .COL_W(COL_W)) u_cols (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state_q == S_FINISH),
        .step    (entering && state_d == S_CLK_LO),
        .col     (pix_col),
        .at_end  (col_end),
        .in_tail (col_tail)
    );

    rowseq_pixel_hold #(.LANES(LANES), .ADDR_W(ADDR_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_px   (entering && state_d == S_CLK_LO),
        .px_in     ({pix_bot, pix_top}),
        .load_addr (entering && state_d == S_ADDR),
        .addr_in   (row_q),
        .px_out    (px_bus),
        .addr_out  (hub_addr)
    );

    assign hub_rgb_top = px_bus[2:0];
    assign hub_rgb_bot = px_bus[5:3];

    // ---------------- output decode ----------------
    always_comb begin
        hub_clk  = 1'b0;
        hub_lat  = 1'b0;
        hub_oe_n = 1'b0;
        row_done = 1'b0;
        unique case (state_q)
            S_IDLE:      ;
            S_CLK_LO:    hub_lat = ovl_q && col_tail;
            S_CLK_HI: begin
                hub_clk = 1'b1;
                hub_lat = ovl_q && col_tail;
            end
            S_BLANK, S_ADDR: begin
                hub_oe_n = 1'b1;
                hub_lat  = ovl_q;
            end
            S_LATCH: begin
                hub_oe_n = 1'b1;
                hub_lat  = 1'b1;
            end
            S_OE_ON_LAT: hub_lat  = 1'b1;
            S_LAT_OFF:   hub_oe_n = 1'b1;
            S_SHOW:      ;
            S_FINISH:    row_done = 1'b1;
            default:     ;
        endcase
    end

    // ---------------- assertions ----------------
    // R3
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hub_clk |-> $stable({hub_rgb_top, hub_rgb_bot}));

    // R6
    addr_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(hub_addr) |-> (hub_oe_n && $past(hub_oe_n)));

    // R6
    late_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hub_lat) && !ovl_q) |-> (hub_oe_n && !hub_clk));

    // R7 and R8
    oe_fall_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hub_oe_n) |-> (hub_lat == !enc_q));

    // R10
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_done |-> (!hub_oe_n && !hub_lat && !hub_clk));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_done |=> !row_done);
endmodule

// File: tb/tb_panel_row_sequencer.sv
module tb_panel_row_sequencer;
    localparam int COLS = 8, ADDR_W = 5, LOW_CYC = 2, HIGH_CYC = 2, GAP_CYC = 2, STRETCH_W = 3;
    localparam int COL_W = $clog2(COLS + 1);

    typedef struct packed {
        logic              clk;
        logic [2:0]        top;
        logic [2:0]        bot;
        logic [ADDR_W-1:0] addr;
        logic              lat;
        logic              oe_n;
        logic              done;
        logic [COL_W-1:0]  col;
    } exp_t;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic cfg_enclosed = 1'b0, cfg_overlap = 1'b0, cfg_wide = 1'b0;
    logic [STRETCH_W-1:0] cfg_stretch = '0;
    logic [ADDR_W-1:0] next_row = '0;
    logic [COL_W-1:0] pix_col;
    logic [2:0] pix_top, pix_bot, hub_rgb_top, hub_rgb_bot;
    logic hub_clk, hub_lat, hub_oe_n, row_done;
    logic [ADDR_W-1:0] hub_addr;

    int seed = 0;
    int checks = 0, errors = 0;
    bit checking = 0;
    string ctx = "R1";
    exp_t q[$];
    exp_t idle_exp = '0;

    always #10 clk = ~clk;

    function automatic logic [5:0] pat(int c, int s);
        return 6'((c * 7 + s * 13) ^ (c << 3) ^ s);
    endfunction

    logic [5:0] pv;
    assign pv      = pat(int'(pix_col), seed);
    assign pix_top = pv[2:0];
    assign pix_bot = pv[5:3];

    panel_row_sequencer #(
        .COLS(COLS), .ADDR_W(ADDR_W), .LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC),
        .GAP_CYC(GAP_CYC), .STRETCH_W(STRETCH_W)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_enclosed(cfg_enclosed), .cfg_overlap(cfg_overlap), .cfg_wide(cfg_wide),
        .cfg_stretch(cfg_stretch), .next_row(next_row), .pix_col(pix_col),
        .pix_top(pix_top), .pix_bot(pix_bot), .hub_clk(hub_clk),
        .hub_rgb_top(hub_rgb_top), .hub_rgb_bot(hub_rgb_bot), .hub_addr(hub_addr),
        .hub_lat(hub_lat), .hub_oe_n(hub_oe_n), .row_done(row_done)
    );

    task automatic cmp(string tag, string name, int act, int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s (%s) %s: actual %0d expected %0d at %0t", tag, ctx, name, act, expv, $time);
        end
    endtask

    // per-cycle comparison against the behavioural model queue
    always @(posedge clk) begin
        #5;
        if (checking) begin
            exp_t e;
            if (q.size() != 0) e = q.pop_front();
            else               e = idle_exp;
            cmp("R4 R5",       "hub_clk",  hub_clk,     e.clk);
            cmp("R3 R11",      "rgb_top",  hub_rgb_top, e.top);
            cmp("R3 R11",      "rgb_bot",  hub_rgb_bot, e.bot);
            cmp("R3 R1",       "pix_col",  pix_col,     e.col);
            cmp("R6 R11",      "hub_addr", hub_addr,    e.addr);
            cmp("R6 R7 R8 R9", "hub_lat",  hub_lat,     e.lat);
            cmp("R6 R7 R8 R1", "hub_oe_n", hub_oe_n,    e.oe_n);
            cmp("R10",         "row_done", row_done,    e.done);
        end
    end

    task automatic push_n(int n, exp_t e);
        for (int i = 0; i < n; i++) q.push_back(e);
    endtask

    task automatic run_row(string tag, bit ovl, bit enc, bit wide, int st,
                           int addr, int sd, bit interfere);
        exp_t e;
        int hi;
        @(negedge clk);
        ctx = tag;
        seed = sd;
        cfg_overlap = ovl; cfg_enclosed = enc; cfg_wide = wide;
        cfg_stretch = STRETCH_W'(st); next_row = ADDR_W'(addr);
        start = 1'b1;
        hi = HIGH_CYC + (wide ? st : 0);
        e = idle_exp;
        e.done = 1'b0;
        e.oe_n = 1'b0;
        for (int c = 0; c < COLS; c++) begin
            logic [5:0] d;
            d = pat(c, sd);
            e.top = d[2:0]; e.bot = d[5:3];
            e.col = COL_W'(c + 1);
            e.lat = ovl && (c >= COLS - 3);          // R9
            e.clk = 1'b0; push_n(LOW_CYC, e);         // R4
            e.clk = 1'b1; push_n(hi, e);              // R5
        end
        e.clk = 1'b0;
        e.oe_n = 1'b1; e.lat = ovl;            push_n(GAP_CYC, e);   // R6 blank
        e.addr = ADDR_W'(addr);                push_n(GAP_CYC, e);   // R6 address
        e.lat = 1'b1;                          push_n(GAP_CYC, e);   // R6 latch
        if (enc) begin e.lat = 1'b0; e.oe_n = 1'b1; end              // R8
        else     begin e.lat = 1'b1; e.oe_n = 1'b0; end              // R7
        push_n(GAP_CYC, e);
        e.lat = 1'b0; e.oe_n = 1'b0;           push_n(GAP_CYC, e);
        e.done = 1'b1;                         push_n(1, e);         // R10
        idle_exp = e;
        idle_exp.done = 1'b0;
        idle_exp.col  = '0;
        @(negedge clk);
        start = 1'b0;
        // R2: configuration changes while busy must not matter
        cfg_overlap = ~ovl; cfg_enclosed = ~enc; cfg_wide = ~wide;
        cfg_stretch = ~STRETCH_W'(st); next_row = ~ADDR_W'(addr);
        if (interfere) begin
            repeat (5) @(negedge clk);
            ctx = {tag, " R2 busy start"};
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        checking = 1;
        ctx = "R1 reset";
        repeat (3) @(negedge clk);
        run_row("offset-after",   0, 0, 0, 0,  5,  1, 0);
        run_row("enclosed-after", 0, 1, 1, 3, 17,  2, 1);
        run_row("offset-overlap", 1, 0, 0, 0, 30,  3, 0);
        run_row("enclosed-ovl",   1, 1, 1, 0,  9,  4, 1);
        run_row("wide-max",       0, 0, 1, 7, 31,  5, 0);
        run_row("back-to-back",   1, 0, 1, 1,  0,  6, 0);
        ctx = "R11 hold";
        repeat (6) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule